// File: doc/BRIEF.md
# Timer Interrupt Status and Routing

This block sits behind a bank of timer channels and turns their fire strobes into interrupts. Each channel has a status bit. A channel delivers its interrupt in one of two ways: on a dedicated wire, or as a single-beat write message sent to an address that software programmed. A per-channel interrupt enable and a global enable decide whether an interrupt is delivered. The status bit follows the trigger type whatever the enables are set to.

Software clears status bits by writing ones to them. Turning on either enable re-delivers any level interrupt that is still pending. Message requests from all channels share one output port. Each request is held on that port until the receiver accepts it.

Top module: `timer_irq_router`

## Requirements
- R1: When `fire[i]` is sampled high, status bit i becomes 1 if `ch_level[i]`=1 (level trigger) and 0 if `ch_level[i]`=0 (edge trigger), visible on `irq_status` after that clock edge.
- R2: The status update of R1 takes place even when `ch_irq_en[i]` or `glb_en` is 0, and in that case no wire or message output is produced.
- R3: A fire is delivered only when `ch_irq_en[i]` and `glb_en` are both 1. A fire that is not delivered on a wire-routed channel lowers that channel's wire.
- R4: A delivered wire interrupt drives `irq_line[i]` high from the edge after the fire. In level mode the line stays high until it is lowered. In edge mode it is high for exactly one cycle.
- R5: When `ch_msg_en[i]`=1, a delivery produces a write request instead of a wire output. The request address is `ch_route[i*64+32 +: 32]` and the request data is `ch_route[i*64 +: 32]`.
- R6: A cycle with `sts_wr`=1 clears every status bit whose `sts_wdata` bit is 1 and lowers that channel's held wire. Bits written as 0 are unchanged. A fire in the same cycle wins over the clear.
- R7: A 0-to-1 change of `ch_irq_en[i]` while status bit i is set and `glb_en`=1 delivers the interrupt again.
- R8: A 0-to-1 change of `glb_en` re-delivers every channel that has `ch_irq_en` set and its status bit set.
- R9: A change of `ch_level[i]` from 1 to 0 lowers the held wire of channel i on that edge.
- R10: `msg_valid`, `msg_addr` and `msg_data` hold steady until `msg_ready` is high. Each channel keeps at most one waiting request, and a delivery that arrives while that request waits is dropped. When several channels are waiting, the lowest index is sent first.
- R11: After reset all status bits, wires and `msg_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fire | input | NCH | Per-channel fire strobes |
| ch_level | input | NCH | Trigger type: 1 level, 0 edge |
| ch_irq_en | input | NCH | Per-channel interrupt enable |
| ch_msg_en | input | NCH | Per-channel message routing enable |
| ch_route | input | NCH*64 | Route words: bits 63:32 address, 31:0 data |
| glb_en | input | 1 | Global interrupt enable |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | NCH | Write-one-to-clear status data |
| irq_status | output | NCH | Status bits |
| irq_line | output | NCH | Wire interrupt outputs |
| msg_valid | output | 1 | Write request valid |
| msg_ready | input | 1 | Write request accepted |
| msg_addr | output | 32 | Write request address |
| msg_data | output | 32 | Write request data |

## Verification
The assertions check the following on every cycle:
- a rising wire always follows a cycle in which both enables were set;
- an edge-mode fire leaves the status bit clear;
- a one-clear without a fire empties the status bit;
- a level-to-edge change drops the held wire;
- a stalled request stays stable;
- grants are at most one-hot.

Some behaviours are sequences that only the bench scenarios show:
- re-delivery on each kind of enable rise;
- the one-cycle width of edge pulses;
- fire winning over a clear;
- the lowest-index ordering and the dropping of a second request while one waits.

// File: rtl/irq_router_pkg.sv
// Shared definitions for the timer interrupt router.
// Assumes a route word of an address half over a data half.
package irq_router_pkg;
    localparam int MSG_AW = 32;
    localparam int MSG_DW = 32;
    localparam int ROUTE_W = MSG_AW + MSG_DW;

    typedef struct packed {
        logic [MSG_AW-1:0] addr;
        logic [MSG_DW-1:0] data;
    } route_t;
endpackage

// File: rtl/irq_chan.sv
// One channel of the router: status bit, wire output and a one-deep
// message slot. Assumes glb_rise is a one-cycle strobe from the top.
module irq_chan
    import irq_router_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic         level,
    input  logic         irq_en,
    input  logic         msg_en,
    input  route_t       route,
    input  logic         glb_en,
    input  logic         glb_rise,
    input  logic         clr,
    input  logic         grant,
    output logic         status,
    output logic         line,
    output logic         pend,
    output route_t       pend_route
);
    logic en_q, level_q, held, pulse;
    logic en_rise, lvl_fall, dlv_fire, redeliver, dlv, raise, lower;

    // Decode delivery and lowering events for this cycle.
    always_comb begin
        en_rise   = irq_en & ~en_q;
        lvl_fall  = level_q & ~level;
        dlv_fire  = fire & irq_en & glb_en;
        redeliver = status & glb_en & irq_en & (en_rise | glb_rise) & ~clr;
        dlv       = dlv_fire | redeliver;
        raise     = dlv & level & ~msg_en;
        lower     = clr | lvl_fall | (fire & ~dlv_fire & ~msg_en);
    end

    // Edge history of the enable and the trigger type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            level_q <= 1'b0;
        end else begin
            en_q    <= irq_en;
            level_q <= level;
        end
    end

    // Status bit: fire sets or clears by trigger type, clear loses to fire.
    always_ff @(posedge clk) begin
        if (!rst_n)      status <= 1'b0;
        else if (fire)   status <= level;
        else if (clr)    status <= 1'b0;
    end

    // Held level wire and one-cycle edge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            if (raise)      held <= 1'b1;
            else if (lower) held <= 1'b0;
            pulse <= dlv & ~level & ~msg_en;
        end
    end

    assign line = held | pulse;

    // One-deep message slot, filled on delivery, emptied on grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend       <= 1'b0;
            pend_route <= '0;
        end else if (grant) begin
            pend <= 1'b0;
        end else if (dlv && msg_en && !pend) begin
            pend       <= 1'b1;
            pend_route <= route;
        end
    end

    p_line_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line) |-> $past(irq_en && glb_en));
    p_edge_fire_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !level) |=> !status);
    p_write_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !fire) |=> !status);
    p_level_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q && !level) |=> !held);
endmodule

// File: rtl/msg_arb.sv
// Fixed-priority picker feeding one registered write-request port.
// Assumes each requester holds pend until it sees its grant.
module msg_arb
    import irq_router_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         pend,
    input  route_t [NCH-1:0]       routes,
    input  logic                   msg_ready,
    output logic [NCH-1:0]         grant,
    output logic                   msg_valid,
    output route_t                 msg_out
);
    logic   free, found;
    route_t pick;

    // Choose the lowest-index waiting channel when the port is free.
    always_comb begin
        free  = ~msg_valid | msg_ready;
        grant = '0;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NCH; i++) begin
            if (free && pend[i] && !found) begin
                found    = 1'b1;
                grant[i] = 1'b1;
                pick     = routes[i];
            end
        end
    end

    // Output register: load on grant, drop after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_out   <= '0;
        end else if (found) begin
            msg_valid <= 1'b1;
            msg_out   <= pick;
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    p_msg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_out)));
    p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

// File: rtl/timer_irq_router.sv
// Top of the timer interrupt router: NCH channels and one shared
// write-request port. Assumes inputs are synchronous to clk.
module timer_irq_router
    import irq_router_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       fire,
    input  logic [NCH-1:0]       ch_level,
    input  logic [NCH-1:0]       ch_irq_en,
    input  logic [NCH-1:0]       ch_msg_en,
    input  logic [NCH*64-1:0]    ch_route,
    input  logic                 glb_en,
    input  logic                 sts_wr,
    input  logic [NCH-1:0]       sts_wdata,
    output logic [NCH-1:0]       irq_status,
    output logic [NCH-1:0]       irq_line,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [31:0]          msg_addr,
    output logic [31:0]          msg_data
);
    logic            glb_q, glb_rise;
    logic [NCH-1:0]  pend, grant;
    route_t [NCH-1:0] pend_routes;
    route_t          msg_out;

    // Global enable edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) glb_q <= 1'b0;
        else        glb_q <= glb_en;
    end

    assign glb_rise = glb_en & ~glb_q;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        irq_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .fire       (fire[i]),
            .level      (ch_level[i]),
            .irq_en     (ch_irq_en[i]),
            .msg_en     (ch_msg_en[i]),
            .route      (route_t'(ch_route[i*ROUTE_W +: ROUTE_W])),
            .glb_en     (glb_en),
            .glb_rise   (glb_rise),
            .clr        (sts_wr & sts_wdata[i]),
            .grant      (grant[i]),
            .status     (irq_status[i]),
            .line       (irq_line[i]),
            .pend       (pend[i]),
            .pend_route (pend_routes[i])
        );
    end

    msg_arb #(.NCH(NCH)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .routes    (pend_routes),
        .msg_ready (msg_ready),
        .grant     (grant),
        .msg_valid (msg_valid),
        .msg_out   (msg_out)
    );

    assign msg_addr = msg_out.addr;
    assign msg_data = msg_out.data;
endmodule

// File: tb/timer_irq_router_test.sv
module timer_irq_router_test;
    localparam int NCH = 3;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] fire = '0, ch_level = '0, ch_irq_en = '0, ch_msg_en = '0, sts_wdata = '0;
    logic [NCH*64-1:0] ch_route = '0;
    logic glb_en = 1'b0, sts_wr = 1'b0, msg_ready = 1'b0;
    logic [NCH-1:0] irq_status, irq_line;
    logic msg_valid;
    logic [31:0] msg_addr, msg_data;
    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    timer_irq_router #(.NCH(NCH)) uut (.*);

    // {level, irq_en, msg_en, glb, fire, exp_status, exp_line} for channel 0
    localparam logic [6:0] VEC [7] = '{
        7'b1_1_0_1_1_1_1,   // R1 R4 level delivered
        7'b0_1_0_1_1_0_1,   // R1 R4 edge pulse
        7'b1_0_0_1_1_1_0,   // R2 enable off
        7'b1_1_0_0_1_1_0,   // R3 global off
        7'b0_0_0_1_1_0_0,   // R2 edge, enable off
        7'b1_1_1_1_1_1_0,   // R5 message route, no wire
        7'b1_1_0_1_0_0_0    // R1 no fire
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R11 status", 64'(irq_status), 0);
        chk("R11 line", 64'(irq_line), 0);
        chk("R11 valid", 64'(msg_valid), 0);

        msg_ready = 1'b1;
        foreach (VEC[k]) begin
            sts_wr = 1'b1; sts_wdata = '1;
            ch_irq_en = '0; glb_en = 1'b0; ch_msg_en = '0;
            tick();
            sts_wr = 1'b0; sts_wdata = '0;
            ch_level[0] = VEC[k][6]; ch_irq_en[0] = VEC[k][5];
            ch_msg_en[0] = VEC[k][4]; glb_en = VEC[k][3]; fire[0] = VEC[k][2];
            tick();
            fire = '0;
            chk($sformatf("R1/R2 vec%0d status", k), 64'(irq_status[0]), 64'(VEC[k][1]));
            chk($sformatf("R3/R4 vec%0d line", k), 64'(irq_line[0]), 64'(VEC[k][0]));
            tick();
            if (VEC[k][2] && !VEC[k][6])
                chk($sformatf("R4 vec%0d pulse end", k), 64'(irq_line[0]), 0);
        end

        // Reset to a clean configuration
        ch_msg_en = '0; ch_irq_en = '0; glb_en = 1'b0; msg_ready = 1'b0;
        sts_wr = 1'b1; sts_wdata = '1; tick(); sts_wr = 1'b0; sts_wdata = '0;
        tick(); tick();

        // R7: enable rise re-delivers pending level interrupt
        ch_level = '1; glb_en = 1'b1; fire[0] = 1'b1; tick(); fire = '0;
        chk("R7 pre line", 64'(irq_line[0]), 0);
        ch_irq_en[0] = 1'b1; tick();
        chk("R7 redeliver", 64'(irq_line[0]), 1);

        // R6: write zero no effect, write one clears
        sts_wr = 1'b1; sts_wdata = '0; tick();
        chk("R6 zero status", 64'(irq_status[0]), 1);
        chk("R6 zero line", 64'(irq_line[0]), 1);
        sts_wdata = 3'b001; tick(); sts_wr = 1'b0; sts_wdata = '0;
        chk("R6 clear status", 64'(irq_status[0]), 0);
        chk("R6 clear line", 64'(irq_line[0]), 0);
        // R6: fire wins over a clear in the same cycle
        fire[0] = 1'b1; sts_wr = 1'b1; sts_wdata = 3'b001; tick();
        fire = '0; sts_wr = 1'b0; sts_wdata = '0;
        chk("R6 fire wins", 64'(irq_status[0]), 1);

        // R9: level to edge lowers held wire, status kept
        ch_level[0] = 1'b0; tick();
        chk("R9 line low", 64'(irq_line[0]), 0);
        chk("R9 status kept", 64'(irq_status[0]), 1);

        // R8: global enable rise re-delivers enabled pending channels
        sts_wr = 1'b1; sts_wdata = '1; tick(); sts_wr = 1'b0; sts_wdata = '0;
        glb_en = 1'b0; ch_level = '1; ch_irq_en = 3'b011; fire = '1; tick(); fire = '0;
        chk("R8 pending", 64'(irq_status), 64'(3'b111));
        chk("R8 pre lines", 64'(irq_line), 0);
        glb_en = 1'b1; tick();
        chk("R8 lines", 64'(irq_line), 64'(3'b011));

        // R5/R10: message routing, ordering, hold and drop
        sts_wr = 1'b1; sts_wdata = '1; tick(); sts_wr = 1'b0; sts_wdata = '0;
        ch_msg_en = 3'b011; ch_route[63:0] = 64'hAAAA0010_12345678;
        ch_route[127:64] = 64'hBBBB0020_9ABCDEF0;
        fire = 3'b011; tick(); fire = '0; tick();
        chk("R5 valid", 64'(msg_valid), 1);
        chk("R5 addr", 64'(msg_addr), 64'h AAAA0010);
        chk("R5 data", 64'(msg_data), 64'h12345678);
        chk("R5 no wire", 64'(irq_line[1:0]), 0);
        fire[0] = 1'b1; tick(); fire = '0;
        fire[0] = 1'b1; tick(); fire = '0;
        chk("R10 hold addr", 64'(msg_addr), 64'hAAAA0010);
        chk("R10 hold valid", 64'(msg_valid), 1);
        msg_ready = 1'b1; tick();
        chk("R10 second ch0", 64'({msg_valid, msg_addr}), {31'd0, 1'b1, 32'hAAAA0010});
        tick();
        chk("R10 then ch1", 64'({msg_valid, msg_addr}), {31'd0, 1'b1, 32'hBBBB0020});
        chk("R10 ch1 data", 64'(msg_data), 64'h9ABCDEF0);
        tick();
        chk("R10 dropped extra", 64'(msg_valid), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule